// File: doc/BRIEF.md
# Page-Buffered Parallel EEPROM Emulator

This block is a synthesizable model of a byte-wide nonvolatile memory with a static-RAM style bus of active-low chip, output and write enables. The bus is sampled in the system clock domain. The storage is an 8192 x 8 array of on-chip registers, addressed by 13 bits. The data bus is split into an input, an output and an output enable.

Writes do not reach the array directly. Each write strobe latches its address and data into a 64-byte page buffer. The first strobe of a load fixes which page the load targets. When no further byte has been loaded for a set window, a self-timed commit copies the loaded bytes into the array. While a load or a commit is pending, reads return status instead of data: bit 7 is the inverse of bit 7 of the last byte loaded, and bit 6 flips on every new read. Software polls either bit to find the end of the write.

Writes can be locked behind a three-byte command sequence. Once protection is set, a write is accepted only when the same sequence precedes it. A six-byte sequence clears protection. Both the window and the commit length are parameters given in clock cycles.

The bus has no valid/ready handshake and offers no back-pressure. A strobe that the block cannot accept, such as one that arrives during a commit or while the array is protected, is dropped without any indication on the bus.

Top module: `pgeeprom_core`

## Requirements
- R1: `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. When no write is pending, `dq_out` then carries the array byte at `addr`.
- R2: A write strobe is the first clock cycle in which `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together. The block takes `addr` and `dq_in` in that cycle. Holding `ce_n`=0 and `we_n`=0 with `oe_n`=0 is not a write.
- R3: A page load holds 1 to 64 bytes. The page is taken from `addr[12:6]` of the first loaded strobe. Every loaded byte lands at offset `addr[5:0]` within that page, whatever its own upper address bits are. If the same offset is written twice in one load, the later byte is the one stored.
- R4: A load closes when WINDOW_CYC cycles pass with no loaded strobe. A commit of COMMIT_CYC cycles then follows, and the array holds the new bytes once the commit ends.
- R5: Offsets of the page that were not loaded keep their previous array values after the commit.
- R6: While a load or a commit is pending, a read returns on bit 7 the inverse of bit 7 of the last byte loaded.
- R7: While a load or a commit is pending, bit 6 of successive reads alternates. After the commit, reads return the true data.
- R8: Write strobes that arrive during a commit are ignored, and the array does not change because of them.
- R9: The writes 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0xA0 set protection. Data writes that follow the sequence, up to the next commit, are accepted.
- R10: While protection is set and not opened by the sequence, a data write is ignored. The array keeps its value, and reads right after the write return array data rather than status.
- R11: The writes 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x80, 0x1555/0xAA, 0x0AAA/0x55, 0x1555/0x20 clear protection, after which plain writes work again.
- R12: Command-sequence writes are never stored in the array. After reset, protection is clear and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 13 | Byte address |
| dq_in | input | 8 | Write data from the bus |
| dq_out | output | 8 | Read data or status to the bus |
| dq_oe | output | 1 | Drive enable for dq_out |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |

## Verification
Some properties are checked on every cycle:
- `dq_oe` follows the three enables.
- Status bit 7 is the inverse of the last loaded byte whenever a write is pending.
- The toggle bit flips at each read start during a pending write.
- No byte enters the page buffer during a commit, while protection is closed, or when the strobe is a command byte.
- The array is written only inside a commit.

Other behaviour can only be shown by the bench's scenarios, which read the array back over the bus:
- the page placement and the last-write-wins rule;
- the preservation of bytes that were not loaded;
- the window and commit timing;
- the full protection sequences, including their effect on later writes.

// File: rtl/pge_pkg.sv
package pge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_COMMIT = 2'd2
  } pge_st_e;

  localparam logic [12:0] CMD_ADDR_HI = 13'h1555;
  localparam logic [12:0] CMD_ADDR_LO = 13'h0AAA;
  localparam logic [7:0]  CMD_LEAD    = 8'hAA;
  localparam logic [7:0]  CMD_SECOND  = 8'h55;
  localparam logic [7:0]  CMD_ARM     = 8'hA0;
  localparam logic [7:0]  CMD_ESCAPE  = 8'h80;
  localparam logic [7:0]  CMD_OFF     = 8'h20;
endpackage

// File: rtl/pge_bus_sense.sv
module pge_bus_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_stb,
  output logic rd_stb,
  output logic rd_act
);
  logic wr_act;
  logic wr_prev, rd_prev;

  assign wr_act = !ce_n && !we_n && oe_n;
  assign rd_act = !ce_n && !oe_n && we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
    end
  end

  // one-cycle pulses at the start of each access
  assign wr_stb = wr_act && !wr_prev;
  assign rd_stb = rd_act && !rd_prev;
endmodule

// File: rtl/pge_cmd_seq.sv
module pge_cmd_seq #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              consume,
  output logic              lock_set,
  output logic              lock_clr
);
  import pge_pkg::*;

  logic [2:0] step;
  logic at_hi, at_lo, hit, restart;

  assign at_hi   = (addr == ADDR_W'(CMD_ADDR_HI));
  assign at_lo   = (addr == ADDR_W'(CMD_ADDR_LO));
  assign restart = at_hi && (data == DATA_W'(CMD_LEAD));

  always_comb begin
    case (step)
      3'd0, 3'd3: hit = at_hi && (data == DATA_W'(CMD_LEAD));
      3'd1, 3'd4: hit = at_lo && (data == DATA_W'(CMD_SECOND));
      3'd2:       hit = at_hi && ((data == DATA_W'(CMD_ARM)) ||
                                  (data == DATA_W'(CMD_ESCAPE)));
      3'd5:       hit = at_hi && (data == DATA_W'(CMD_OFF));
      default:    hit = 1'b0;
    endcase
  end

  assign consume  = stb && (hit || restart);
  assign lock_set = stb && hit && (step == 3'd2) && (data == DATA_W'(CMD_ARM));
  assign lock_clr = stb && hit && (step == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= 3'd0;
    end else if (stb) begin
      if (hit) begin
        if (lock_set || lock_clr) step <= 3'd0;
        else                      step <= step + 3'd1;
      end else if (restart) begin
        step <= 3'd1;
      end else begin
        step <= 3'd0;
      end
    end
  end
endmodule

// File: rtl/pge_page_buf.sv
module pge_page_buf #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [PAGE_W-1:0] ld_off,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  input  logic [PAGE_W-1:0] rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] ent [PAGE_N];
  logic [PAGE_N-1:0] vld;

  for (genvar i = 0; i < PAGE_N; i++) begin : g_ent
    logic sel;
    assign sel = ld && (ld_off == PAGE_W'(i));

    always_ff @(posedge clk) begin
      if (sel) ent[i] <= ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld[i] <= 1'b0;
      else if (clr) vld[i] <= 1'b0;
      else if (sel) vld[i] <= 1'b1;
    end
  end

  assign rd_data = ent[rd_off];
  assign rd_vld  = vld[rd_off];
endmodule

// File: rtl/pge_array.sv
module pge_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pgeeprom_core.sv
module pgeeprom_core #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 6,
  parameter int WINDOW_CYC = 37500,
  parameter int COMMIT_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n
);
  import pge_pkg::*;

  localparam int PAGE_N = 1 << PAGE_W;
  localparam int BANK_W = ADDR_W - PAGE_W;
  localparam int CSPAN  = (COMMIT_CYC > PAGE_N) ? COMMIT_CYC : PAGE_N;
  localparam int CCW    = $clog2(CSPAN + 1);
  localparam int WCW    = $clog2(WINDOW_CYC + 1);

  pge_st_e           st;
  logic              busy, in_commit;
  logic              wr_stb, rd_stb, rd_act;
  logic              cmd_stb, consume, lock_set, lock_clr;
  logic              locked, grant;
  logic              buf_ld, buf_clr, buf_vld;
  logic [DATA_W-1:0] buf_data;
  logic [BANK_W-1:0] page_base;
  logic [DATA_W-1:0] last_data;
  logic              tog;
  logic [CCW-1:0]    ccnt;
  logic [WCW-1:0]    wcnt;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [DATA_W-1:0] arr_rdata;
  logic              commit_end;

  assign busy      = (st != ST_IDLE);
  assign in_commit = (st == ST_COMMIT);

  pge_bus_sense u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .rd_act (rd_act)
  );

  assign cmd_stb = wr_stb && !in_commit;

  pge_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (cmd_stb),
    .addr     (addr),
    .data     (dq_in),
    .consume  (consume),
    .lock_set (lock_set),
    .lock_clr (lock_clr)
  );

  // a data byte enters the page only when not committing, not a command,
  // and protection is either clear or opened by the arming sequence
  assign buf_ld     = cmd_stb && !consume && (!locked || grant);
  assign commit_end = in_commit && (ccnt == CCW'(COMMIT_CYC - 1));
  assign buf_clr    = commit_end;

  pge_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (buf_ld),
    .ld_off  (addr[PAGE_W-1:0]),
    .ld_data (dq_in),
    .clr     (buf_clr),
    .rd_off  (ccnt[PAGE_W-1:0]),
    .rd_data (buf_data),
    .rd_vld  (buf_vld)
  );

  // one page byte per cycle during the first PAGE_N cycles of the commit
  assign arr_we    = in_commit && (ccnt < CCW'(PAGE_N)) && buf_vld;
  assign arr_waddr = {page_base, ccnt[PAGE_W-1:0]};

  pge_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (buf_data),
    .raddr (addr),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wcnt      <= '0;
      ccnt      <= '0;
      page_base <= '0;
      last_data <= '0;
      tog       <= 1'b0;
      locked    <= 1'b0;
      grant     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (buf_ld) begin
            st        <= ST_LOAD;
            page_base <= addr[ADDR_W-1:PAGE_W];
            wcnt      <= '0;
          end
        end
        ST_LOAD: begin
          if (buf_ld) begin
            wcnt <= '0;
          end else if (wcnt == WCW'(WINDOW_CYC - 1)) begin
            st    <= ST_COMMIT;
            ccnt  <= '0;
            grant <= 1'b0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        ST_COMMIT: begin
          if (commit_end) st   <= ST_IDLE;
          else            ccnt <= ccnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase

      if (buf_ld)          last_data <= dq_in;
      if (busy && rd_stb)  tog       <= ~tog;

      if (lock_set) begin
        locked <= 1'b1;
        grant  <= 1'b1;
      end else if (lock_clr) begin
        locked <= 1'b0;
        grant  <= 1'b0;
      end
    end
  end

  assign dq_oe  = rd_act;
  assign dq_out = busy ? {~last_data[DATA_W-1], tog, last_data[DATA_W-3:0]}
                       : arr_rdata;
endmodule

// File: rtl/pge_core_chk.sv
module pge_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              dq_oe,
  input logic [DATA_W-1:0] dq_out,
  input logic              busy,
  input logic              in_commit,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              buf_ld,
  input logic              consume,
  input logic              locked,
  input logic              grant,
  input logic              last_top,
  input logic              tog,
  input logic              arr_we
);
  p_oe_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n) |-> dq_oe);

  p_oe_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> !dq_oe);

  p_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_out[DATA_W-1] != last_top));

  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb) |=> (tog != $past(tog)));

  p_arr_in_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> in_commit);

  p_drop_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_commit && wr_stb) |-> !buf_ld);

  p_locked_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !grant && wr_stb && !consume) |-> !buf_ld);

  p_cmd_not_stored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> !buf_ld);
endmodule

bind pgeeprom_core pge_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .oe_n      (oe_n),
  .we_n      (we_n),
  .dq_oe     (dq_oe),
  .dq_out    (dq_out),
  .busy      (busy),
  .in_commit (in_commit),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .buf_ld    (buf_ld),
  .consume   (consume),
  .locked    (locked),
  .grant     (grant),
  .last_top  (last_data[DATA_W-1]),
  .tog       (tog),
  .arr_we    (arr_we)
);

// File: tb/pgeeprom_core_tb_top.sv
module pgeeprom_core_tb_top;
  localparam int WIN = 16;
  localparam int COM = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] mdl   [8192];
  bit         known [8192];
  logic [7:0] pend  [64];
  bit         pend_v[64];

  always #2 clk = ~clk;

  pgeeprom_core #(.WINDOW_CYC(WIN), .COMMIT_CYC(COM)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n)
  );

  function automatic logic [12:0] pa(input int pg, input int off);
    return 13'((pg << 6) | off);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); @(negedge clk); d = dq_out; oe = dq_oe; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_done();
    repeat (WIN + COM + 8) @(negedge clk);
  endtask

  task automatic chkmem(input string tag, input logic [12:0] a);
    logic [7:0] d; logic oe;
    rd(a, d, oe);
    chk(tag, d, mdl[a]);
  endtask

  task automatic put(input logic [12:0] a, input logic [7:0] d);
    mdl[a] = d; known[a] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d1, d2, dd;
    logic oe;
    int seed;
    seed = $urandom(32'd4242);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12: idle after reset
    chk("R1 idle oe", {7'd0, dq_oe}, 8'h00);

    // setup: two full pages, two command addresses
    for (int i = 0; i < 64; i++) wr(pa(4, i), 8'(i * 3 + 1));
    wait_done();
    for (int i = 0; i < 64; i++) put(pa(4, i), 8'(i * 3 + 1));
    for (int i = 0; i < 64; i++) wr(pa(36, i), 8'(i) ^ 8'h5A);
    wait_done();
    for (int i = 0; i < 64; i++) put(pa(36, i), 8'(i) ^ 8'h5A);
    wr(13'h1555, 8'h3C); wait_done(); put(13'h1555, 8'h3C);
    wr(13'h0AAA, 8'hC3); wait_done(); put(13'h0AAA, 8'hC3);
    for (int i = 0; i < 64; i++) chkmem("R3 full page", pa(4, i));
    chkmem("R12 unprotected after reset", 13'h1555);
    rd(pa(36, 7), d1, oe);
    chk("R1 read oe", {7'd0, oe}, 8'h01);

    // R6 / R7: polling during a pending write
    wr(pa(4, 5), 8'hB4);
    rd(pa(4, 5), d1, oe);
    chk("R6 inverted bit7", {7'd0, d1[7]}, 8'h00);
    rd(pa(4, 5), d2, oe);
    chk("R7 toggle bit6", {7'd0, d1[6] ^ d2[6]}, 8'h01);
    wait_done(); put(pa(4, 5), 8'hB4);
    chkmem("R7 true data after commit", pa(4, 5));

    // R5 / R4: single byte, neighbours kept
    wr(pa(4, 16), 8'h99);
    wait_done(); put(pa(4, 16), 8'h99);
    chkmem("R4 committed", pa(4, 16));
    chkmem("R5 lower neighbour", pa(4, 15));
    chkmem("R5 upper neighbour", pa(4, 17));

    // R3: overwrite within load, foreign page bits ignored
    wr(pa(4, 3), 8'h10);
    wr(pa(4, 3), 8'h20);
    wr(pa(36, 5), 8'h30);
    wait_done(); put(pa(4, 3), 8'h20); put(pa(4, 5), 8'h30);
    chkmem("R3 last write wins", pa(4, 3));
    chkmem("R3 offset in first page", pa(4, 5));
    chkmem("R3 other page untouched", pa(36, 5));

    // R2: enables low with oe_n low is not a write
    @(negedge clk); addr = pa(4, 20); dq_in = 8'h00; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    repeat (4) @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    wait_done();
    chkmem("R2 no strobe with oe low", pa(4, 20));

    // R8: strobes during commit dropped
    wr(pa(4, 8), 8'h44);
    repeat (WIN + 6) @(negedge clk);
    wr(pa(4, 9), 8'h57);
    wr(pa(36, 1), 8'h66);
    wait_done(); put(pa(4, 8), 8'h44);
    chkmem("R8 first byte stored", pa(4, 8));
    chkmem("R8 dropped same page", pa(4, 9));
    chkmem("R8 dropped other page", pa(36, 1));

    // R9 / R12: enable protection with a following write
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
    wr(pa(4, 2), 8'h5A);
    wait_done(); put(pa(4, 2), 8'h5A);
    chkmem("R9 armed write stored", pa(4, 2));
    chkmem("R12 command byte hi", 13'h1555);
    chkmem("R12 command byte lo", 13'h0AAA);

    // R10: protected plain write ignored
    wr(pa(4, 12), 8'hEE);
    rd(pa(4, 12), dd, oe);
    chk("R10 no status after blocked write", dd, mdl[pa(4, 12)]);
    wait_done();
    chkmem("R10 array unchanged", pa(4, 12));

    // R11: disable then plain write
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
    wr(pa(4, 12), 8'hEE);
    wait_done(); put(pa(4, 12), 8'hEE);
    chkmem("R11 write after disable", pa(4, 12));

    // random page loads (R3, R4, R5)
    for (int it = 0; it < 6; it++) begin
      int pg, n;
      pg = int'($urandom % 128);
      n  = 1 + int'($urandom % 64);
      for (int k = 0; k < 64; k++) pend_v[k] = 1'b0;
      for (int k = 0; k < n; k++) begin
        int off;
        logic [7:0] d;
        off = int'($urandom % 64);
        d   = 8'($urandom);
        if (pa(pg, off) == 13'h1555 && d == 8'hAA) d = 8'hAB;
        wr(pa(pg, off), d);
        pend[off] = d; pend_v[off] = 1'b1;
      end
      wait_done();
      for (int k = 0; k < 64; k++) if (pend_v[k]) put(pa(pg, k), pend[k]);
      for (int k = 0; k < 64; k++) if (known[pa(pg, k)]) chkmem("R5 random page", pa(pg, k));
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule